// File: doc/BRIEF.md
# USB OTG Role Detection Controller

This block watches the ID level of a USB OTG connector and the session-valid indication of the VBUS comparator. Both arrive asynchronously and pass through a synchronizer. While software has turned on ID sampling, any change of either level raises a sticky event bit. Each event bit can be routed onto a single interrupt line through its own enable. Software clears an event by writing 1 to it.

An optional automatic mode lets the block choose the port role itself whenever an event is detected. The connector acts as a peripheral only when ID is high and a session is valid at the same time. In every other case it acts as host. The role decision updates the peripheral flag, the D+ and D- pulldown values and the VBUS drive in a single clock edge. When automatic mode is off, software owns all of these fields through a small 32-bit register port with writes and combinational reads.

Top module: `otg_role_ctl`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0, and the role outputs show host with VBUS drive off and both pulldowns off.
- R2: Registers sit at byte addresses CONTROL 0x00 (bit 0 automatic mode, bit 31 peripheral flag), EVENT 0x04, EVENT_EN 0x08, SENSE 0x0C and LINES 0x10. Any other address and any undefined bit reads 0.
- R3: While sampling is on, a change of the ID level sets EVENT bit 11 and a change of session-valid sets EVENT bit 12. The bit is set on the third rising clock edge after the input changes. The sampled levels can be read at SENSE bit 19 (ID) and bit 20 (session-valid).
- R4: Writing 1 to an EVENT bit clears it and writing 0 leaves it unchanged. If a new event is detected on the same edge as the clearing write, the bit stays set.
- R5: While SENSE bit 5 (sampling enable) is 0, the sampled levels are held, no event is raised and the role does not change. When sampling is turned on, any difference between the pin and the held level counts as a change. The held levels are 0 after reset.
- R6: `irq_o` is the OR over bits 11 and 12 of EVENT AND EVENT_EN, registered one cycle.
- R7: In automatic mode, an event with ID = 1 and session-valid = 1 selects peripheral. This sets CONTROL bit 31 to 1, clears the D+ pulldown value, sets the D- pulldown value and clears VBUS drive (SENSE bit 4).
- R8: In automatic mode, an event with any other level combination selects host. This clears CONTROL bit 31, sets both pulldown values and sets VBUS drive.
- R9: LINES holds the D+ pulldown value at bit 18 with its enable at bit 19, and the D- value at bit 16 with its enable at bit 17. A pulldown output is high only when both its value and its enable are 1.
- R10: With automatic mode off, events leave the role fields untouched. Software writes set the peripheral flag, VBUS drive and pulldown values directly.
- R11: In automatic mode, when a software write to a role field lands on the same edge as a hardware role update, the hardware value wins. The other fields written by that software write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_pin_i | input | 1 | Asynchronous ID level from the connector |
| sess_vld_i | input | 1 | Asynchronous session-valid level |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt line |
| peri_mode_o | output | 1 | 1 = peripheral role, 0 = host role |
| dp_pulldown_o | output | 1 | D+ pulldown control |
| dm_pulldown_o | output | 1 | D- pulldown control |
| vbus_drive_o | output | 1 | VBUS supply drive |

## Verification
Two collisions are provoked on purpose. In the first, a clearing write to EVENT lands on the same edge that detects a new change on the same bit. In the second, a software write to CONTROL in automatic mode meets a hardware role update. Both are staged by changing a pin right after a falling edge and then issuing the register write two falling edges later, so that the write is captured on the third rising edge. In the first case the event bit must still read 1. In the second the peripheral flag and VBUS drive must carry the host decision, while the automatic-mode bit from the same write is kept. Random pin patterns with random enables and random clears are checked against a bench model of events, interrupt and role.

// File: rtl/otg_role_pkg.sv
`timescale 1ns/1ps
package otg_role_pkg;
  // byte offsets of the registers
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_EVENT = 'h04;
  localparam int OFS_EVEN  = 'h08;
  localparam int OFS_SENSE = 'h0C;
  localparam int OFS_LINES = 'h10;

  // CONTROL fields
  localparam int B_AUTO     = 0;
  localparam int B_PERI     = 31;
  // EVENT / EVENT_EN fields
  localparam int B_EV_ID    = 11;
  localparam int B_EV_SESS  = 12;
  // SENSE fields
  localparam int B_VBUS     = 4;
  localparam int B_SAMP_EN  = 5;
  localparam int B_LIVE_ID  = 19;
  localparam int B_LIVE_VLD = 20;
  // LINES fields
  localparam int B_DM_VAL   = 16;
  localparam int B_DM_EN    = 17;
  localparam int B_DP_VAL   = 18;
  localparam int B_DP_EN    = 19;

  // index of each watched level inside the level vector
  localparam int L_ID   = 0;
  localparam int L_SESS = 1;
  localparam int N_LVL  = 2;

  typedef struct packed {
    logic peri;
    logic dp_val;
    logic dm_val;
    logic vbus;
  } role_t;
endpackage

// File: rtl/otg_pin_sync.sv
`timescale 1ns/1ps
module otg_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/otg_change_det.sv
`timescale 1ns/1ps
module otg_change_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] held_o,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    chg_o  = '0;
    if (samp_en_i) begin
      held_d = lvl_i;
      chg_o  = lvl_i ^ held_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held_o = held_q;

  // R5: levels frozen while sampling is off
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en_i |=> $stable(held_q));
  // R5: no change reported while sampling is off
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en_i |-> (chg_o == '0));
endmodule

// File: rtl/otg_role_dec.sv
`timescale 1ns/1ps
module otg_role_dec
  import otg_role_pkg::*;
(
  input  logic  id_i,
  input  logic  sess_i,
  output role_t role_o
);
  logic b_dev;

  always_comb begin
    b_dev         = id_i & sess_i;
    role_o.peri   = b_dev;
    role_o.dp_val = ~b_dev;
    role_o.dm_val = 1'b1;
    role_o.vbus   = ~b_dev;
  end
endmodule

// File: rtl/otg_role_ctl.sv
`timescale 1ns/1ps
module otg_role_ctl
  import otg_role_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_pin_i,
  input  logic              sess_vld_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              peri_mode_o,
  output logic              dp_pulldown_o,
  output logic              dm_pulldown_o,
  output logic              vbus_drive_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_EVEN  = ADDR_W'(OFS_EVEN);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_LINES = ADDR_W'(OFS_LINES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // input path
  logic [N_LVL-1:0] pins, lvl_s, held, chg;
  assign pins[L_ID]   = id_pin_i;
  assign pins[L_SESS] = sess_vld_i;

  logic samp_en_q, samp_en_d;

  otg_pin_sync #(.WIDTH(N_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(pins), .q_o(lvl_s));

  otg_change_det #(.WIDTH(N_LVL)) u_det (
    .clk(clk), .rst_n(rst_sync_n), .samp_en_i(samp_en_q),
    .lvl_i(lvl_s), .held_o(held), .chg_o(chg));

  role_t role_hw;
  otg_role_dec u_dec (
    .id_i(lvl_s[L_ID]), .sess_i(lvl_s[L_SESS]), .role_o(role_hw));

  // register state
  logic             auto_q, auto_d;
  role_t            role_q, role_d;
  logic [N_LVL-1:0] ev_q, ev_d, ien_q, ien_d, ev_clr;
  logic             dp_en_q, dp_en_d, dm_en_q, dm_en_d;
  logic             irq_q, irq_d;

  logic wr_ctrl, wr_event, wr_even, wr_sense, wr_lines, hw_upd;

  always_comb begin
    wr_ctrl  = bus_wr_i && (bus_addr_i == A_CTRL);
    wr_event = bus_wr_i && (bus_addr_i == A_EVENT);
    wr_even  = bus_wr_i && (bus_addr_i == A_EVEN);
    wr_sense = bus_wr_i && (bus_addr_i == A_SENSE);
    wr_lines = bus_wr_i && (bus_addr_i == A_LINES);
    hw_upd   = auto_q && (|chg);
  end

  // next state
  always_comb begin
    auto_d    = auto_q;
    role_d    = role_q;
    ien_d     = ien_q;
    samp_en_d = samp_en_q;
    dp_en_d   = dp_en_q;
    dm_en_d   = dm_en_q;

    ev_clr         = '0;
    ev_clr[L_ID]   = wr_event & bus_wdata_i[B_EV_ID];
    ev_clr[L_SESS] = wr_event & bus_wdata_i[B_EV_SESS];
    ev_d           = (ev_q & ~ev_clr) | chg;

    if (wr_ctrl) begin
      auto_d      = bus_wdata_i[B_AUTO];
      role_d.peri = bus_wdata_i[B_PERI];
    end
    if (wr_even) begin
      ien_d[L_ID]   = bus_wdata_i[B_EV_ID];
      ien_d[L_SESS] = bus_wdata_i[B_EV_SESS];
    end
    if (wr_sense) begin
      samp_en_d   = bus_wdata_i[B_SAMP_EN];
      role_d.vbus = bus_wdata_i[B_VBUS];
    end
    if (wr_lines) begin
      dp_en_d       = bus_wdata_i[B_DP_EN];
      dm_en_d       = bus_wdata_i[B_DM_EN];
      role_d.dp_val = bus_wdata_i[B_DP_VAL];
      role_d.dm_val = bus_wdata_i[B_DM_VAL];
    end
    // the hardware decision overrides software on the role fields
    if (hw_upd) role_d = role_hw;

    irq_d = |(ev_q & ien_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      auto_q    <= 1'b0;
      role_q    <= '0;
      ev_q      <= '0;
      ien_q     <= '0;
      samp_en_q <= 1'b0;
      dp_en_q   <= 1'b0;
      dm_en_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      auto_q    <= auto_d;
      role_q    <= role_d;
      ev_q      <= ev_d;
      ien_q     <= ien_d;
      samp_en_q <= samp_en_d;
      dp_en_q   <= dp_en_d;
      dm_en_q   <= dm_en_d;
      irq_q     <= irq_d;
    end
  end

  // read side
  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_AUTO] = auto_q;
        bus_rdata_o[B_PERI] = role_q.peri;
      end
      A_EVENT: begin
        bus_rdata_o[B_EV_ID]   = ev_q[L_ID];
        bus_rdata_o[B_EV_SESS] = ev_q[L_SESS];
      end
      A_EVEN: begin
        bus_rdata_o[B_EV_ID]   = ien_q[L_ID];
        bus_rdata_o[B_EV_SESS] = ien_q[L_SESS];
      end
      A_SENSE: begin
        bus_rdata_o[B_VBUS]     = role_q.vbus;
        bus_rdata_o[B_SAMP_EN]  = samp_en_q;
        bus_rdata_o[B_LIVE_ID]  = held[L_ID];
        bus_rdata_o[B_LIVE_VLD] = held[L_SESS];
      end
      A_LINES: begin
        bus_rdata_o[B_DP_EN]  = dp_en_q;
        bus_rdata_o[B_DP_VAL] = role_q.dp_val;
        bus_rdata_o[B_DM_EN]  = dm_en_q;
        bus_rdata_o[B_DM_VAL] = role_q.dm_val;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i;

  assign irq_o         = irq_q;
  assign peri_mode_o   = role_q.peri;
  assign vbus_drive_o  = role_q.vbus;
  assign dp_pulldown_o = role_q.dp_val & dp_en_q;
  assign dm_pulldown_o = role_q.dm_val & dm_en_q;

  // assertions
  // R3 and R4: a detected change always lands in EVENT, a clear cannot hide it
  a_r3_event_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chg[L_ID] |=> ev_q[L_ID]);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_event && bus_wdata_i[B_EV_SESS] && !chg[L_SESS]) |=> !ev_q[L_SESS]);
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_event && ev_q[L_ID]) |=> ev_q[L_ID]);
  // R6: interrupt follows enabled events one edge later
  a_r6_irq_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(ev_q & ien_q)) |=> irq_o);
  a_r6_irq_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|(ev_q & ien_q)) |=> !irq_o);
  // R7: B-device decision
  a_r7_peri_role: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hw_upd && lvl_s[L_ID] && lvl_s[L_SESS])
      |=> (peri_mode_o && !vbus_drive_o && !role_q.dp_val && role_q.dm_val));
  // R8 and R11: host decision, even against a concurrent software write
  a_r8_host_role: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hw_upd && !(lvl_s[L_ID] && lvl_s[L_SESS]))
      |=> (!peri_mode_o && vbus_drive_o && role_q.dp_val && role_q.dm_val));
  // R10: manual mode, role flag moves only by a CONTROL write
  a_r10_manual_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!auto_q && !wr_ctrl) |=> $stable(peri_mode_o));
endmodule

// File: tb/otg_role_ctl_test.sv
`timescale 1ns/1ps
module otg_role_ctl_test;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_EV = 8'h04, A_IEN = 8'h08,
                         A_SNS = 8'h0C, A_LN = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_pin, sess_vld, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, peri, dp_pd, dm_pd, vbus;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;   // 50 MHz

  otg_role_ctl #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .id_pin_i(id_pin), .sess_vld_i(sess_vld),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .peri_mode_o(peri),
    .dp_pulldown_o(dp_pd), .dm_pulldown_o(dm_pd), .vbus_drive_o(vbus));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic is_b_dev(input logic i, input logic v);
    return i & v;
  endfunction

  function automatic logic [31:0] ev_bits(input logic ci, input logic cv);
    return (ci ? 32'h800 : 32'h0) | (cv ? 32'h1000 : 32'h0);
  endfunction

  logic [31:0] r;
  logic        m_id, m_vld, m_peri;
  logic [31:0] m_ev, m_ien;

  initial begin : wdog
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    rst_n = 1'b0; id_pin = 0; sess_vld = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    rd(A_EV, r);   chk("R1 event", r, 0);
    rd(A_IEN, r);  chk("R1 enable", r, 0);
    rd(A_SNS, r);  chk("R1 sense", r, 0);
    rd(A_LN, r);   chk("R1 lines", r, 0);
    chk("R1 outputs", {27'd0, irq, peri, dp_pd, dm_pd, vbus}, 0);
    // R2 unmapped address and undefined bits read 0
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, r); chk("R2 unmapped", r, 0);
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, r); chk("R2 enable layout", r, 32'h1800);
    wr(A_IEN, 0);

    // R5 sampling off: no event, held level stays 0
    id_pin = 1;
    idle(6);
    rd(A_EV, r);  chk("R5 no event", r, 0);
    rd(A_SNS, r); chk("R5 held level", r, 0);

    // R3 enabling sampling sees the pending ID difference
    wr(A_SNS, 32'h20);
    idle(4);
    rd(A_EV, r);  chk("R3 id event", r, 32'h800);
    rd(A_SNS, r); chk("R3 live id", r, 32'h0008_0020);

    // R4 write 0 keeps, write 1 clears
    wr(A_EV, 0);
    rd(A_EV, r); chk("R4 zero keeps", r, 32'h800);
    wr(A_EV, 32'h800);
    rd(A_EV, r); chk("R4 one clears", r, 0);

    // R6 interrupt on session-valid change
    wr(A_IEN, 32'h1000);
    sess_vld = 1;
    idle(6);
    rd(A_EV, r); chk("R3 sess event", r, 32'h1000);
    chk("R6 irq on", irq, 1);
    wr(A_EV, 32'h1000);
    idle(2);
    chk("R6 irq off", irq, 0);

    // R9 pulldown gating
    wr(A_LN, 32'h0005_0000);
    chk("R9 gated off", {dp_pd, dm_pd}, 0);
    wr(A_LN, 32'h000F_0000);
    chk("R9 both on", {dp_pd, dm_pd}, 2'b11);
    wr(A_LN, 32'h000A_0000);
    chk("R9 enables only", {dp_pd, dm_pd}, 0);

    // R10 manual mode: events do not touch role, software does
    wr(A_LN, 32'h000F_0000);
    id_pin = 0;
    idle(6);
    chk("R10 role held", {peri, vbus, dp_pd, dm_pd}, 4'b0011);
    wr(A_CTRL, 32'h8000_0000);
    wr(A_SNS, 32'h30);
    chk("R10 sw role", {peri, vbus}, 2'b11);

    // known state, then automatic mode with random patterns
    wr(A_SNS, 32'h20);
    wr(A_CTRL, 32'h1);
    wr(A_EV, 32'h1800);
    idle(2);
    m_id = id_pin; m_vld = sess_vld; m_ev = 0; m_ien = 32'h1000;
    m_peri = 0;
    chk("R8 start host", {peri, vbus, dp_pd, dm_pd}, 4'b0011);
    vbus_fix: begin
      // start from host with VBUS on so the model is uniform
      wr(A_SNS, 32'h30);
    end
    for (int it = 0; it < 60; it++) begin
      logic ni, nv;
      logic [31:0] clr;
      ni = 1'($urandom_range(0, 1));
      nv = 1'($urandom_range(0, 1));
      m_ien = 32'($urandom_range(0, 3)) << 11;
      wr(A_IEN, m_ien);
      id_pin = ni; sess_vld = nv;
      idle(6);
      if (ni != m_id || nv != m_vld) m_peri = is_b_dev(ni, nv);
      m_ev = m_ev | ev_bits(ni != m_id, nv != m_vld);
      m_id = ni; m_vld = nv;
      rd(A_EV, r); chk("R3 random event", r, m_ev);
      chk("R6 random irq", irq, |(m_ev & m_ien));
      if (m_peri) chk("R7 peripheral", {peri, vbus, dp_pd, dm_pd}, 4'b1001);
      else        chk("R8 host", {peri, vbus, dp_pd, dm_pd}, 4'b0111);
      if ($urandom_range(0, 1) == 1) begin
        clr = 32'($urandom_range(0, 3)) << 11;
        wr(A_EV, clr);
        m_ev = m_ev & ~clr;
        rd(A_EV, r); chk("R4 random clear", r, m_ev);
      end
    end

    // R11 software write meets hardware update on the same edge
    id_pin = 1; sess_vld = 1;
    idle(6);
    chk("R7 setup peripheral", peri, 1);
    id_pin = 0;
    idle(2);
    wr(A_CTRL, 32'h8000_0001);
    chk("R11 hw wins", {peri, vbus}, 2'b01);
    rd(A_CTRL, r); chk("R11 auto kept", r, 32'h1);

    // R4 new event on the same edge as its clear
    wr(A_EV, 32'h1800);
    rd(A_EV, r); chk("R4 cleared", r, 0);
    sess_vld = 0;
    idle(2);
    wr(A_EV, 32'h1000);
    rd(A_EV, r); chk("R4 set beats clear", r, 32'h1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule